// File: doc/BRIEF.md
# DMA Channel Register Block

This block holds the programmable state of one DMA channel that serves an attached peripheral. A host reaches four 32-bit registers through a simple request port: a control/status word, a running transfer address, a byte count and an upper-address word. The control/status word gathers the channel's interrupt handling, the peripheral reset request, the FIFO-drain hint, the transfer direction and the channel enable. Writing it also has side effects on three output pins: a gated interrupt to the host, a one-cycle reset pulse to the peripheral and a DMA-enable level to the peripheral.

The peripheral reports interrupts on a level input. The block records each rising edge as a pending flag and forwards it to the host only while interrupts are enabled. The peripheral also reports each finished transfer with a one-cycle strobe and a byte length, and the address register moves forward by that length. The memory traffic itself is handled elsewhere.

The host port uses a valid/ready handshake. `bus_ready` is held high, so the block never applies back-pressure: every cycle with `bus_valid` high is one complete access. A write takes effect at that clock edge. Read data is combinational from the register that `bus_addr[3:2]` selects.

Top module: `dma_chan_regs`

## Requirements
- R1: `bus_addr[3:2]` selects the register: 0 is control/status, 1 is address, 2 is byte count and 3 is upper address. `bus_rdata` shows the selected register's stored value. Registers 2 and 3 store any written value unchanged.
- R2: After reset the control/status register reads 0xA0000000 and registers 1 to 3 read zero. `host_irq`, `periph_rst` and `dma_en` are low.
- R3: On a control/status write, bits 24:3 take the written value, subject to R7. Bits 31:25 and 2:0 keep their old value. The result is then ORed with 0xA0000000.
- R4: A rising edge on `periph_irq` sets pending (bit 0) and raises `host_irq` if interrupt enable (bit 4) is set. A falling edge while pending is set clears pending and lowers `host_irq` if enable is set.
- R5: On a control/status write whose value has bit 4 set, `host_irq` rises if pending was already set. If the value has bit 4 clear, `host_irq` falls when pending or the old bit 4 was set. Otherwise `host_irq` keeps its level.
- R6: A control/status write with bit 7 set drives `periph_rst` high for exactly the next cycle.
- R7: When bit 7 of the written value is clear, a set bit 6 (drain) is stored as 0, and a written value of all zeros stores bit 6 as 1. When bit 7 is set, bit 6 is stored as written.
- R8: `dma_en` rises when a control/status write changes bit 9 from 0 to 1, and falls when a write changes it from 1 to 0.
- R9: A write to the address register also sets bit 26 (loaded) of the control/status register. Only reset clears bit 26.
- R10: A cycle with `xfer_valid` high adds `xfer_len` to the address register. An address-register write in the same cycle wins, and the increment is dropped.
- R11: `bus_ready` is always high, so every cycle with `bus_valid` high is one complete access.
- R12: When an interrupt edge and a control/status write fall in the same cycle, the write is applied first. The edge is then handled using the interrupt enable just written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Host access request |
| bus_ready | output | 1 | Access accepted (always high) |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte address; bits 3:2 pick the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the selected register |
| xfer_valid | input | 1 | One-cycle transfer-done strobe |
| xfer_len | input | 16 | Bytes moved by the finished transfer |
| periph_irq | input | 1 | Peripheral interrupt level |
| host_irq | output | 1 | Gated interrupt to the host |
| periph_rst | output | 1 | One-cycle peripheral reset pulse |
| dma_en | output | 1 | DMA-enable level to the peripheral |

## Verification
The hardest state to reach from the ports is a pending interrupt that arrived while enable was off and is later exposed by a control/status write. It takes an edge on `periph_irq` with bit 4 clear, followed by writes that turn enable on and then off again. The bench also lines up an interrupt edge and a control/status write in the same cycle to exercise R12. It collides an address write with a transfer strobe for R10. A long pseudo-random phase then mixes all of these events against the bench's reference model.

// File: rtl/dcr_pkg.sv
package dcr_pkg;
  parameter int unsigned REG_W = 32;
  localparam int unsigned IDX_W = 2;

  typedef enum logic [IDX_W-1:0] {
    IDX_CSR   = 2'd0,
    IDX_ADDR  = 2'd1,
    IDX_COUNT = 2'd2,
    IDX_UPPER = 2'd3
  } reg_idx_e;

  localparam int unsigned B_PEND   = 0;
  localparam int unsigned B_IEN    = 4;
  localparam int unsigned B_DRAIN  = 6;
  localparam int unsigned B_RST    = 7;
  localparam int unsigned B_DIR    = 8;
  localparam int unsigned B_DEN    = 9;
  localparam int unsigned B_LOADED = 26;

  localparam logic [REG_W-1:0] RO_MASK = 32'hFE00_0007;
  localparam logic [REG_W-1:0] VERSION = 32'hA000_0000;
endpackage

// File: rtl/dcr_csr.sv
module dcr_csr
  import dcr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wdata,
  input  logic             set_loaded,
  input  logic             irq_in,
  output logic [REG_W-1:0] csr_q,
  output logic             host_irq,
  output logic             periph_rst,
  output logic             dma_en
);
  logic             irq_prev;
  logic [REG_W-1:0] shaped;
  logic [REG_W-1:0] merged;
  logic [REG_W-1:0] csr_d;
  logic             irq_d;
  logic             rise;
  logic             fall;

  // Drain shaping: reset request has priority, then explicit drain, then all-zero write.
  always_comb begin
    shaped = wdata;
    if (!wdata[B_RST]) begin
      if (wdata[B_DRAIN])      shaped[B_DRAIN] = 1'b0;
      else if (wdata == '0)    shaped[B_DRAIN] = 1'b1;
    end
  end

  assign merged = (csr_q & RO_MASK) | (shaped & ~RO_MASK) | VERSION;
  assign rise   = irq_in & ~irq_prev;
  assign fall   = ~irq_in & irq_prev;

  // Host write first, then the peripheral edge against the written enable.
  always_comb begin
    csr_d = wr_en ? merged : csr_q;
    irq_d = host_irq;
    if (wr_en) begin
      if (wdata[B_IEN]) begin
        if (csr_q[B_PEND]) irq_d = 1'b1;
      end else if (csr_q[B_PEND] || csr_q[B_IEN]) begin
        irq_d = 1'b0;
      end
    end
    if (set_loaded) csr_d[B_LOADED] = 1'b1;
    if (rise) begin
      csr_d[B_PEND] = 1'b1;
      if (csr_d[B_IEN]) irq_d = 1'b1;
    end else if (fall && csr_d[B_PEND]) begin
      csr_d[B_PEND] = 1'b0;
      if (csr_d[B_IEN]) irq_d = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      csr_q      <= VERSION;
      host_irq   <= 1'b0;
      periph_rst <= 1'b0;
      dma_en     <= 1'b0;
      irq_prev   <= 1'b0;
    end else begin
      csr_q      <= csr_d;
      host_irq   <= irq_d;
      irq_prev   <= irq_in;
      periph_rst <= wr_en & wdata[B_RST];
      if (wr_en) begin
        if (merged[B_DEN] && !csr_q[B_DEN])      dma_en <= 1'b1;
        else if (!merged[B_DEN] && csr_q[B_DEN]) dma_en <= 1'b0;
      end
    end
  end

  a_r6_rst_from_write: assert property (@(posedge clk) disable iff (!rst_n)
    periph_rst |-> $past(wr_en && wdata[B_RST]));

  a_r8_en_rise_from_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dma_en) |-> $past(wr_en && wdata[B_DEN]));

  a_r4_pend_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_in && !irq_prev) |=> csr_q[B_PEND]);

  a_r12_out_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_in && !irq_prev && (wr_en ? wdata[B_IEN] : csr_q[B_IEN])) |=> host_irq);

  a_r9_loaded_set: assert property (@(posedge clk) disable iff (!rst_n)
    set_loaded |=> csr_q[B_LOADED]);
endmodule

// File: rtl/dcr_addr.sv
module dcr_addr
  import dcr_pkg::*;
#(
  parameter int unsigned LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wdata,
  input  logic             inc,
  input  logic [LEN_W-1:0] len,
  output logic [REG_W-1:0] addr_q
);
  localparam int unsigned PAD_W = REG_W - LEN_W;
  logic [REG_W-1:0] len_ext;

  assign len_ext = {{PAD_W{1'b0}}, len};

  always_ff @(posedge clk) begin
    if (!rst_n)     addr_q <= '0;
    else if (wr_en) addr_q <= wdata;
    else if (inc)   addr_q <= addr_q + len_ext;
  end

  a_r10_increment: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !wr_en) |=> addr_q == $past(addr_q) + $past(len_ext));

  a_r10_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> addr_q == $past(wdata));
endmodule

// File: rtl/dcr_plain_regs.sv
module dcr_plain_regs
  import dcr_pkg::*;
#(
  parameter int unsigned N_REGS = 2,
  parameter int unsigned BASE   = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [IDX_W-1:0]            wr_idx,
  input  logic [REG_W-1:0]            wdata,
  output logic [N_REGS-1:0][REG_W-1:0] q
);
  for (genvar g = 0; g < N_REGS; g++) begin : g_reg
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(BASE + g);
    always_ff @(posedge clk) begin
      if (!rst_n)                          q[g] <= '0;
      else if (wr_en && wr_idx == MY_IDX)  q[g] <= wdata;
    end
  end
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dcr_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  output logic              bus_ready,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic              xfer_valid,
  input  logic [LEN_W-1:0]  xfer_len,
  input  logic              periph_irq,
  output logic              host_irq,
  output logic              periph_rst,
  output logic              dma_en
);
  localparam int unsigned N_PLAIN = 2;

  logic                         wr;
  reg_idx_e                     idx;
  logic [REG_W-1:0]             csr_q;
  logic [REG_W-1:0]             addr_q;
  logic [N_PLAIN-1:0][REG_W-1:0] plain_q;

  assign bus_ready = 1'b1;
  assign wr        = bus_valid & bus_write;
  assign idx       = reg_idx_e'(bus_addr[3:2]);

  dcr_csr u_csr (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr && idx == IDX_CSR),
    .wdata      (bus_wdata),
    .set_loaded (wr && idx == IDX_ADDR),
    .irq_in     (periph_irq),
    .csr_q      (csr_q),
    .host_irq   (host_irq),
    .periph_rst (periph_rst),
    .dma_en     (dma_en)
  );

  dcr_addr #(.LEN_W(LEN_W)) u_addr (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr && idx == IDX_ADDR),
    .wdata  (bus_wdata),
    .inc    (xfer_valid),
    .len    (xfer_len),
    .addr_q (addr_q)
  );

  dcr_plain_regs #(.N_REGS(N_PLAIN), .BASE(2)) u_plain (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr),
    .wr_idx (bus_addr[3:2]),
    .wdata  (bus_wdata),
    .q      (plain_q)
  );

  always_comb begin
    unique case (idx)
      IDX_CSR:   bus_rdata = csr_q;
      IDX_ADDR:  bus_rdata = addr_q;
      IDX_COUNT: bus_rdata = plain_q[0];
      IDX_UPPER: bus_rdata = plain_q[1];
      default:   bus_rdata = '0;
    endcase
  end

  a_r3_version_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && idx == IDX_CSR) |=> (csr_q & VERSION) == VERSION);
endmodule

// File: tb/dma_chan_regs_tb.sv
module dma_chan_regs_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_ready;
  logic        bus_write = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        xfer_valid = 1'b0;
  logic [15:0] xfer_len = '0;
  logic        periph_irq = 1'b0;
  logic        host_irq, periph_rst, dma_en;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 0;
  bit cmp_on = 0;

  always #10 clk = ~clk;

  dma_chan_regs u_dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_ready(bus_ready),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .xfer_valid(xfer_valid), .xfer_len(xfer_len),
    .periph_irq(periph_irq), .host_irq(host_irq), .periph_rst(periph_rst),
    .dma_en(dma_en)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Behavioural reference model
  logic [31:0] m_reg [4];
  logic m_irq, m_rst, m_en, m_prev;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_reg[0] = 32'hA000_0000; m_reg[1] = 0; m_reg[2] = 0; m_reg[3] = 0;
      m_irq = 0; m_rst = 0; m_en = 0; m_prev = 0;
    end else begin
      logic [31:0] v, old;
      int k;
      k = int'(bus_addr[3:2]);
      old = m_reg[0];
      m_rst = 0;
      if (bus_valid && bus_write) begin
        if (k == 0) begin
          v = bus_wdata;
          if (!v[7]) begin
            if (v[6]) v[6] = 0;
            else if (v == 0) v[6] = 1;
          end
          m_reg[0] = (old & 32'hFE00_0007) | (v & 32'h01FF_FFF8) | 32'hA000_0000;
          if (bus_wdata[4]) begin
            if (old[0]) m_irq = 1;
          end else if (old[0] || old[4]) m_irq = 0;
          m_rst = bus_wdata[7];
          m_en = m_reg[0][9];
        end else begin
          m_reg[k] = bus_wdata;
          if (k == 1) m_reg[0][26] = 1;
        end
      end
      if (xfer_valid && !(bus_valid && bus_write && k == 1))
        m_reg[1] = m_reg[1] + {16'h0, xfer_len};
      if (periph_irq && !m_prev) begin
        m_reg[0][0] = 1;
        if (m_reg[0][4]) m_irq = 1;
      end else if (!periph_irq && m_prev && m_reg[0][0]) begin
        m_reg[0][0] = 0;
        if (m_reg[0][4]) m_irq = 0;
      end
      m_prev = periph_irq;
    end
  end

  always @(negedge clk) begin
    if (rst_n && cmp_on && !done) begin
      chk("R4 R5 R12 host_irq model", {31'h0, host_irq}, {31'h0, m_irq});
      chk("R6 periph_rst model", {31'h0, periph_rst}, {31'h0, m_rst});
      chk("R8 dma_en model", {31'h0, dma_en}, {31'h0, m_en});
      chk("R1 rdata model", bus_rdata, m_reg[int'(bus_addr[3:2])]);
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(input int idx, input logic [31:0] d);
    bus_valid = 1; bus_write = 1; bus_addr = 4'(idx << 2); bus_wdata = d;
    step();
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic rd(input int idx, input logic [31:0] exp, input string tag);
    bus_valid = 1; bus_write = 0; bus_addr = 4'(idx << 2);
    @(negedge clk);
    chk(tag, bus_rdata, exp);
    step();
    bus_valid = 0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles >= 100000 && !done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    cmp_on = 1;
    // R2 reset state
    chk("R2 host_irq reset", {31'h0, host_irq}, 0);
    chk("R2 dma_en reset", {31'h0, dma_en}, 0);
    chk("R11 bus_ready", {31'h0, bus_ready}, 1);
    rd(0, 32'hA000_0000, "R2 csr reset");
    rd(1, 0, "R2 addr reset");
    rd(3, 0, "R2 upper reset");
    // R1 plain registers
    wr(2, 32'h1234_5678);
    wr(3, 32'hCAFE_0000);
    rd(2, 32'h1234_5678, "R1 count");
    rd(3, 32'hCAFE_0000, "R1 upper");
    // R3 / R6 / R8
    wr(0, 32'hFFFF_FFFF);
    chk("R6 pulse high", {31'h0, periph_rst}, 1);
    chk("R8 enable rise", {31'h0, dma_en}, 1);
    rd(0, 32'hA1FF_FFF8, "R3 R7 csr all ones");
    chk("R6 pulse ended", {31'h0, periph_rst}, 0);
    // R7 drain
    wr(0, 32'h0000_0040);
    chk("R8 enable fall", {31'h0, dma_en}, 0);
    rd(0, 32'hA000_0000, "R7 drain cleared");
    wr(0, 32'h0);
    rd(0, 32'hA000_0040, "R7 zero sets drain");
    // R4 interrupt edges with enable
    wr(0, 32'h10);
    periph_irq = 1; step();
    chk("R4 host_irq on rise", {31'h0, host_irq}, 1);
    rd(0, 32'hA000_0011, "R4 pending set");
    periph_irq = 0; step();
    chk("R4 host_irq on fall", {31'h0, host_irq}, 0);
    rd(0, 32'hA000_0010, "R4 pending cleared");
    // R5 masked pending then exposed by write
    wr(0, 32'h8);
    periph_irq = 1; step();
    chk("R4 masked edge", {31'h0, host_irq}, 0);
    rd(0, 32'hA000_0009, "R4 masked pending");
    wr(0, 32'h10);
    chk("R5 enable exposes pending", {31'h0, host_irq}, 1);
    wr(0, 32'h8);
    chk("R5 disable lowers", {31'h0, host_irq}, 0);
    periph_irq = 0; step();
    rd(0, 32'hA000_0008, "R4 fall clears pending");
    // R9 / R10
    wr(1, 32'h0000_1000);
    rd(0, 32'hA400_0008, "R9 loaded set");
    xfer_valid = 1; xfer_len = 16'h20; step(); xfer_valid = 0;
    rd(1, 32'h0000_1020, "R10 increment");
    xfer_valid = 1; xfer_len = 16'h30;
    wr(1, 32'h0000_2000);
    xfer_valid = 0;
    rd(1, 32'h0000_2000, "R10 write wins");
    // R12 same-cycle write and edge
    periph_irq = 1;
    wr(0, 32'h10);
    chk("R12 edge uses written enable", {31'h0, host_irq}, 1);
    rd(0, 32'hA400_0011, "R12 csr after collision");
    wr(0, 32'h0);
    chk("R5 zero write lowers", {31'h0, host_irq}, 0);
    rd(0, 32'hA400_0041, "R7 R3 csr after zero write");
    periph_irq = 0; step();
    rd(0, 32'hA400_0040, "R9 loaded stays");
    // Pseudo-random phase against the model
    for (int i = 0; i < 3000; i++) begin
      bus_valid  = ($urandom % 3) != 0;
      bus_write  = ($urandom % 2) != 0;
      bus_addr   = 4'($urandom % 16);
      case ($urandom % 4)
        0: bus_wdata = 32'h0;
        1: bus_wdata = $urandom & 32'h0000_02D0;
        default: bus_wdata = $urandom;
      endcase
      xfer_valid = ($urandom % 4) == 0;
      xfer_len   = 16'($urandom);
      if (($urandom % 5) == 0) periph_irq = ~periph_irq;
      step();
    end
    bus_valid = 0; xfer_valid = 0;
    step();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule